// File: doc/BRIEF.md
# Clocked Dual-Edge One-Shot Pulse Generator

This block is a synchronous replacement for an RC-timed monostable. Each channel has two trigger inputs: one fires on a falling edge and one fires on a rising edge. Each trigger works only while the other input is at the level that enables it, so either input can act as an inhibit for the other. An active-low clear input overrides everything. The block drives a pulse output and its complement. The pulse length is a count of clock cycles supplied on an input bus, so no external timing parts are needed.

All channel inputs are asynchronous to the clock. They pass through two-flop synchronisers, and edges are detected on the synchronised values. Once a pulse has started it runs for its full length unless clear stops it. It cannot be retriggered or stretched. A release of clear can also start a pulse, but only if the channel was armed beforehand. The channel is armed whenever the falling-edge input is high or the rising-edge input is low while clear is inactive, and a fired pulse disarms it. The top level holds a parameterised number of independent channels.

Top module: `pulse_oneshot`

## Requirements
- R1: After reset every pulse output is low and every complement output is high. The synchronised inputs reset to the inhibited state: falling-edge input high, rising-edge input low, clear active.
- R2: A falling edge on `a_fall_i` while `b_rise_i` is high starts a pulse. The pulse output rises at the third rising clock edge after the input change.
- R3: A rising edge on `b_rise_i` while `a_fall_i` is low starts a pulse, with the same three-edge latency.
- R4: While `a_fall_i` is held high, or while `b_rise_i` is held low, no pulse starts and the output stays low.
- R5: While `clr_n_i` is low the output is low. Lowering clear during a pulse ends it at the third rising clock edge after the change, so a pulse cut k cycles after its trigger lasts k cycles.
- R6: Edges on either trigger input during a pulse have no effect. The pulse is neither restarted nor extended.
- R7: The pulse lasts exactly the number of cycles on the channel's `width_i` field, sampled when the pulse starts. A value of 0 gives 1 cycle. The length does not depend on how long the trigger stays active.
- R8: A rising edge on `clr_n_i` while `a_fall_i` is low and `b_rise_i` is high starts a pulse only if the channel is armed. The channel is armed when `a_fall_i` is high or `b_rise_i` is low while clear is inactive, and firing a pulse disarms it.
- R9: `qn_o` is always the bitwise complement of `q_o`.
- R10: Channels are independent. Activity on one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_fall_i | input | NCH | Falling-edge trigger, one bit per channel |
| b_rise_i | input | NCH | Rising-edge trigger, one bit per channel |
| clr_n_i | input | NCH | Active-low clear, one bit per channel |
| width_i | input | NCH*CW | Pulse length in cycles; channel c uses bits [c*CW +: CW] |
| q_o | output | NCH | Pulse output per channel |
| qn_o | output | NCH | Complement of q_o |

## Verification
Directed sequences measure pulse lengths exactly:
- a falling edge on A and a rising edge on B, separately;
- each trigger blocked by its inhibit level;
- trigger toggles during a running pulse, to expose retriggering;
- a long and a short trigger with the same width value;
- a width value of zero;
- clear lowered partway through a pulse, which should yield a pulse exactly as long as the delay before the cut;
- clear released twice under the same input levels, where only the armed release may fire.

A seeded random phase then toggles every input of both channels and changes the width values at random. It compares each output cycle by cycle against a model built from the requirements. This exposes latency errors, width values sampled at the wrong time, and edges that should have been ignored.

// File: rtl/pulse_oneshot_pkg.sv
package pulse_oneshot_pkg;
  parameter int unsigned OS_CW = 16;
  localparam int unsigned OS_SYNC_W = 3;
  // synchronised vector layout: {clear_n, b, a}
  localparam int unsigned OS_IDX_A   = 0;
  localparam int unsigned OS_IDX_B   = 1;
  localparam int unsigned OS_IDX_CLR = 2;
  // inhibited idle state: a high, b low, clear active
  localparam logic [OS_SYNC_W-1:0] OS_SYNC_RST = 3'b001;
endpackage

// File: rtl/pulse_oneshot_sync.sv
module pulse_oneshot_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= RST_VAL[i];
        stable_q <= RST_VAL[i];
      end else begin
        meta_q   <= d_i[i];
        stable_q <= meta_q;
      end
    end
    assign q_o[i] = stable_q;
  end
endmodule

// File: rtl/pulse_oneshot_chan.sv
module pulse_oneshot_chan
  import pulse_oneshot_pkg::*;
#(
  parameter int unsigned CW = OS_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_i,
  input  logic          b_i,
  input  logic          clr_n_i,
  input  logic [CW-1:0] width_i,
  output logic          q_o,
  output logic          qn_o
);
  logic [OS_SYNC_W-1:0] sync_s, prev_q;
  logic a_s, b_s, clr_s, a_p, b_p, clr_p;
  logic armed_q, armed_d;
  logic busy_q, busy_d;
  logic [CW-1:0] remain_q, remain_d;
  logic hit_a, hit_b, hit_clr, fire;

  pulse_oneshot_sync #(.W(OS_SYNC_W), .RST_VAL(OS_SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({clr_n_i, b_i, a_i}),
    .q_o   (sync_s)
  );

  assign a_s   = sync_s[OS_IDX_A];
  assign b_s   = sync_s[OS_IDX_B];
  assign clr_s = sync_s[OS_IDX_CLR];
  assign a_p   = prev_q[OS_IDX_A];
  assign b_p   = prev_q[OS_IDX_B];
  assign clr_p = prev_q[OS_IDX_CLR];

  // trigger decode
  always_comb begin
    hit_a   = a_p && !a_s && b_s;
    hit_b   = !b_p && b_s && !a_s;
    hit_clr = !clr_p && clr_s && !a_s && b_s && armed_q;
    fire    = clr_s && !busy_q && (hit_a || hit_b || hit_clr);
  end

  // next state
  always_comb begin
    armed_d  = armed_q;
    busy_d   = busy_q;
    remain_d = remain_q;
    if (fire) begin
      armed_d = 1'b0;
    end else if (clr_s && (a_s || !b_s)) begin
      armed_d = 1'b1;
    end
    if (!clr_s) begin
      busy_d   = 1'b0;
      remain_d = '0;
    end else if (busy_q) begin
      if (remain_q == '0) begin
        busy_d = 1'b0;
      end else begin
        remain_d = remain_q - 1'b1;
      end
    end else if (fire) begin
      busy_d   = 1'b1;
      remain_d = (width_i == '0) ? '0 : width_i - 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= OS_SYNC_RST;
      armed_q  <= 1'b0;
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      prev_q   <= sync_s;
      armed_q  <= armed_d;
      busy_q   <= busy_d;
      remain_q <= remain_d;
    end
  end

  assign q_o  = busy_q;
  assign qn_o = ~busy_q;

  AST_CLR_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> !busy_q && remain_q == '0); // R5
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && clr_s && remain_q != '0 |=> busy_q && remain_q == $past(remain_q) - 1'b1); // R6
  AST_INHIBIT_A: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && a_s |=> !busy_q); // R4
  AST_INHIBIT_B: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !b_s |=> !busy_q); // R4
  AST_CLR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s && !clr_p && !armed_q && a_s == a_p && b_s == b_p |=> !busy_q); // R8
endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
  import pulse_oneshot_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned CW  = OS_CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    a_fall_i,
  input  logic [NCH-1:0]    b_rise_i,
  input  logic [NCH-1:0]    clr_n_i,
  input  logic [NCH*CW-1:0] width_i,
  output logic [NCH-1:0]    q_o,
  output logic [NCH-1:0]    qn_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pulse_oneshot_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_i     (a_fall_i[c]),
      .b_i     (b_rise_i[c]),
      .clr_n_i (clr_n_i[c]),
      .width_i (width_i[c*CW +: CW]),
      .q_o     (q_o[c]),
      .qn_o    (qn_o[c])
    );
  end

  AST_QN_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    qn_o == ~q_o); // R9
endmodule

// File: tb/pulse_oneshot_tb.sv
module pulse_oneshot_tb;
  localparam int NCH = 2;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [NCH-1:0] a, b, cn;
  logic [NCH*CW-1:0] w;
  logic [NCH-1:0] q, qn;

  pulse_oneshot #(.NCH(NCH), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_fall_i(a), .b_rise_i(b), .clr_n_i(cn),
    .width_i(w), .q_o(q), .qn_o(qn)
  );

  // reference model state, layout {clear_n, b, a}
  logic [2:0] m_s1 [NCH];
  logic [2:0] m_s2 [NCH];
  logic [2:0] m_p  [NCH];
  logic m_arm [NCH];
  logic m_busy [NCH];
  logic [CW-1:0] m_rem [NCH];

  int nchk = 0, nfail = 0, ch1_hits = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_s1[c] = 3'b001; m_s2[c] = 3'b001; m_p[c] = 3'b001;
      m_arm[c] = 0; m_busy[c] = 0; m_rem[c] = '0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      logic as, bs, cs, fa, fb, fc, fire, nbusy, narm;
      logic [CW-1:0] nrem, wc;
      as = m_s2[c][0]; bs = m_s2[c][1]; cs = m_s2[c][2];
      wc = w[c*CW +: CW];
      fa = m_p[c][0] && !as && bs;
      fb = !m_p[c][1] && bs && !as;
      fc = !m_p[c][2] && cs && !as && bs && m_arm[c];
      fire = cs && !m_busy[c] && (fa || fb || fc);
      narm = fire ? 1'b0 : ((cs && (as || !bs)) ? 1'b1 : m_arm[c]);
      nbusy = m_busy[c]; nrem = m_rem[c];
      if (!cs) begin nbusy = 0; nrem = '0; end
      else if (m_busy[c]) begin
        if (m_rem[c] == '0) nbusy = 0; else nrem = m_rem[c] - 1'b1;
      end else if (fire) begin
        nbusy = 1; nrem = (wc == '0) ? '0 : wc - 1'b1;
      end
      m_arm[c] = narm; m_busy[c] = nbusy; m_rem[c] = nrem;
      m_p[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = {cn[c], b[c], a[c]};
    end
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      chk(tag, q[c], m_busy[c]);
      chk("R9", qn[c], !q[c]);
    end
    ch1_hits += q[1];
  endtask

  task automatic count_q(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin cyc(); k += q[0]; end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(20 * 150000);
    chk("watchdog", 0, 1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
    end
    $finish;
  end

  initial begin
    int k;
    void'($urandom(1234));
    rst_n = 0; a = '1; b = '0; cn = '1; w = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", q, 0);
    chk("R1", qn, 2'b11);
    rst_n = 1;
    run(6);

    // R2: falling A with B high
    tag = "R2"; b[0] = 1; run(4);
    w[0 +: CW] = 5; a[0] = 0;
    count_q(20, k); chk("R2 width 5", k, 5);

    // R3: rising B with A low
    tag = "R3"; b[0] = 0; run(6);
    w[0 +: CW] = 3; b[0] = 1;
    count_q(20, k); chk("R3 width 3", k, 3);

    // R4: inhibits
    tag = "R4"; a[0] = 1; b[0] = 0; run(5);
    b[0] = 1; count_q(12, k); chk("R4 B rise with A high", k, 0);
    b[0] = 0; run(4);
    a[0] = 0; count_q(12, k); chk("R4 A fall with B low", k, 0);

    // R6: toggles during a pulse are ignored
    tag = "R6"; a[0] = 1; b[0] = 1; run(5);
    w[0 +: CW] = 20; a[0] = 0; k = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 4) a[0] = 1;
      if (i == 6) a[0] = 0;
      if (i == 8) b[0] = 0;
      if (i == 9) b[0] = 1;
      cyc(); k += q[0];
    end
    chk("R6 no retrigger", k, 20);

    // R7: zero width, long and short trigger
    tag = "R7"; a[0] = 1; run(4);
    w[0 +: CW] = 0; a[0] = 0;
    count_q(10, k); chk("R7 zero width", k, 1);
    a[0] = 1; run(4); w[0 +: CW] = 7; a[0] = 0;
    count_q(20, k); chk("R7 long trigger", k, 7);
    a[0] = 1; run(4); a[0] = 0; cyc(); a[0] = 1;
    count_q(20, k); chk("R7 short trigger", k, 7);

    // R5: clear cuts a pulse
    tag = "R5"; b[0] = 1; run(4);
    w[0 +: CW] = 50; a[0] = 0; k = 0;
    for (int i = 0; i < 40; i++) begin
      if (i == 10) cn[0] = 0;
      cyc(); k += q[0];
    end
    chk("R5 clear cut", k, 10);
    tag = "R8"; cn[0] = 1;
    count_q(10, k); chk("R8 unarmed release", k, 0);

    // R8: armed clear release fires, second release does not
    a[0] = 1; run(4); cn[0] = 0; run(4); a[0] = 0; run(4);
    w[0 +: CW] = 4; cn[0] = 1;
    count_q(15, k); chk("R8 armed release", k, 4);
    cn[0] = 0; run(4); cn[0] = 1;
    count_q(15, k); chk("R8 disarmed after fire", k, 0);

    chk("R10 idle channel untouched", ch1_hits, 0);

    // random phase against the model
    tag = "R2 R3 R6 R7 model";
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(0, 5) == 0) a[c] = ~a[c];
        if ($urandom_range(0, 5) == 0) b[c] = ~b[c];
        if ($urandom_range(0, 40) == 0) cn[c] = ~cn[c];
        if ($urandom_range(0, 3) == 0) w[c*CW +: CW] = CW'($urandom_range(0, 12));
      end
      cyc();
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
    end
    $finish;
  end
endmodule